// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and a 32-bit static memory built from four independent byte-wide arrays. Each array has its own active-low enable and write strobe. All arrays share the address bus, one active-low output enable and the data bus. The host presents a word address, a write word, a four-bit lane mask and a direction flag. The controller then walks the memory pins through a fixed, cycle-counted sequence and reports completion with a one-cycle done pulse. For reads, the captured word comes back along with the pulse.

Every timing interval is a parameter in clock cycles. The integrator rounds each memory nanosecond limit up against the clock period. A write runs through setup, strobe and recovery. A read waits out the access time with the output enable low. It then spends a programmed turnaround gap with the bus released before the next access can start. The gap ensures the controller never drives the data bus while a memory array may still be driving it.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `req_ready` is 1, all `mem_ce_n` and `mem_we_n` bits are 1, `mem_oe_n` is 1, `mem_dq_oe` is 0 and `rsp_done` is 0.
- R2: Mask bit i selects byte lane i, which is data bits [8i+7:8i] and pins `mem_ce_n[i]` and `mem_we_n[i]`. During an access, only lanes set in the mask ever see their enable low. A mask of zero enables no lane.
- R3: A write first drives data with the lane enables low and write strobes high for SETUP_CYC cycles. The strobes of the selected lanes then go low for exactly WR_PULSE_CYC cycles. Enables and data stay on for WR_RECOV_CYC more cycles. `rsp_done` is seen SETUP_CYC+WR_PULSE_CYC+WR_RECOV_CYC clock edges after the accepting edge.
- R4: While any enable stays low from one cycle to the next, `mem_addr` does not change. While `mem_dq_oe` stays high, `mem_dq_out` does not change.
- R5: The output enable is held high whenever any write strobe is low. The controller never drives the data bus while `mem_oe_n` is low.
- R6: A read holds `mem_oe_n` low with the selected lanes enabled for RD_WAIT_CYC cycles. It captures `mem_dq_in` on the edge that ends that window. `rsp_done` is seen RD_WAIT_CYC+TURN_CYC edges after the accepting edge.
- R7: The bytes of `rsp_rdata` for lanes outside the read mask are zero.
- R8: After a read, for TURN_CYC cycles all enables are high, `mem_oe_n` is high and `mem_dq_oe` is low. Only after that can a later access drive the bus, so the bus never has two drivers.
- R9: `req_ready` is low from the accepting edge until the controller returns to idle. A request presented while `req_ready` is low has no effect on the memory.
- R10: `rsp_done` lasts exactly one cycle and is followed by an idle cycle. `rsp_rdata` keeps its value until the next read completes, so a write leaves it unchanged.
- R11: A write strobe is never low on a lane whose enable is high. Between two strobes on a lane, the strobe stays high for at least WR_RECOV_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | LANES*LANE_W | Write word |
| req_mask | input | LANES | Byte-lane select, bit i = lane i |
| req_ready | output | 1 | Controller idle, request accepted when high |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LANES*LANE_W | Captured read word, unselected lanes zero |
| mem_addr | output | ADDR_W | Shared memory address |
| mem_ce_n | output | LANES | Per-lane active-low enable |
| mem_we_n | output | LANES | Per-lane active-low write strobe |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq_out | output | LANES*LANE_W | Data to drive onto the bus |
| mem_dq_in | input | LANES*LANE_W | Data read from the bus |
| mem_dq_oe | output | 1 | Controller drives the bus when high |

## Verification
The bench builds the block with a one-cycle setup, a three-cycle strobe, one recovery cycle, a three-cycle read window and a two-cycle turnaround. The behavioural lane model only returns valid data in the third read cycle, so capturing one edge early yields a garbage byte. The model also keeps driving the bus for two cycles after a read ends, so a shortened turnaround collides with a following write. Because the strobe is longer than one cycle, width, recovery-gap and data-stability faults show up as distinct model violations rather than as silent rewrites.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SETUP      = 3'd1,
    ST_WR_PULSE   = 3'd2,
    ST_WR_RECOVER = 3'd3,
    ST_RD_WAIT    = 3'd4,
    ST_TURN       = 3'd5,
    ST_DONE       = 3'd6
  } seq_state_t;

  // Number of cycles a timed stage lasts.
  function automatic int stage_len(seq_state_t st, int s_c, int p_c, int r_c,
                                   int rd_c, int t_c);
    case (st)
      ST_SETUP:      return s_c;
      ST_WR_PULSE:   return p_c;
      ST_WR_RECOVER: return r_c;
      ST_RD_WAIT:    return rd_c;
      ST_TURN:       return t_c;
      default:       return 1;
    endcase
  endfunction

  // Stage ordering; only the idle stage looks at the direction.
  function automatic seq_state_t stage_next(seq_state_t st, logic is_write);
    case (st)
      ST_IDLE:       return is_write ? ST_SETUP : ST_RD_WAIT;
      ST_SETUP:      return ST_WR_PULSE;
      ST_WR_PULSE:   return ST_WR_RECOVER;
      ST_WR_RECOVER: return ST_DONE;
      ST_RD_WAIT:    return ST_TURN;
      ST_TURN:       return ST_DONE;
      default:       return ST_IDLE;
    endcase
  endfunction

  // Stages in which the selected lanes are enabled.
  function automatic logic lane_selected(seq_state_t st);
    return (st == ST_SETUP) || (st == ST_WR_PULSE) ||
           (st == ST_WR_RECOVER) || (st == ST_RD_WAIT);
  endfunction

  // Stages in which the controller owns the data bus.
  function automatic logic drives_bus(seq_state_t st);
    return (st == ST_SETUP) || (st == ST_WR_PULSE) || (st == ST_WR_RECOVER);
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int SETUP_CYC    = 1,
  parameter int WR_PULSE_CYC = 3,
  parameter int WR_RECOV_CYC = 1,
  parameter int RD_WAIT_CYC  = 3,
  parameter int TURN_CYC     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_write,
  output seq_state_t state_o,
  output logic       stage_last_o
);

  localparam int MAX_LEN = max_of(max_of(max_of(SETUP_CYC, WR_PULSE_CYC),
                                         max_of(WR_RECOV_CYC, RD_WAIT_CYC)),
                                  TURN_CYC);
  localparam int CNT_W = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  seq_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             timed;

  function automatic logic [CNT_W-1:0] load_of(seq_state_t s);
    return CNT_W'(stage_len(s, SETUP_CYC, WR_PULSE_CYC, WR_RECOV_CYC,
                            RD_WAIT_CYC, TURN_CYC) - 1);
  endfunction

  assign timed        = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign stage_last_o = timed && (cnt_q == '0);
  assign state_o      = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (st_q == ST_IDLE) begin
      if (start) begin
        st_q  <= stage_next(ST_IDLE, start_write);
        cnt_q <= load_of(stage_next(ST_IDLE, start_write));
      end
    end else if (st_q == ST_DONE) begin
      st_q <= ST_IDLE;
    end else if (cnt_q == '0) begin
      st_q  <= stage_next(st_q, 1'b0);
      cnt_q <= load_of(stage_next(st_q, 1'b0));
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sram_lane_drv.sv
`timescale 1ns/1ps
module sram_lane_drv
  import sram_lane_pkg::*;
#(
  parameter int LANES = 4
) (
  input  seq_state_t       state_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] ce_n_o,
  output logic [LANES-1:0] we_n_o
);

  logic sel;
  logic strobe;

  assign sel    = lane_selected(state_i);
  assign strobe = (state_i == ST_WR_PULSE);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign ce_n_o[i] = ~(sel & mask_i[i]);
    assign we_n_o[i] = ~(strobe & mask_i[i]);
  end

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata_o
);

  logic [DW-1:0] nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign nxt[i*LANE_W +: LANE_W] = mask_i[i] ? dq_i[i*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_o <= '0;
    else if (capture_i) rdata_o <= nxt;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int LANES        = 4,
  parameter int LANE_W       = 8,
  parameter int SETUP_CYC    = 1,
  parameter int WR_PULSE_CYC = 3,
  parameter int WR_RECOV_CYC = 1,
  parameter int RD_WAIT_CYC  = 3,
  parameter int TURN_CYC     = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_mask,
  output logic                    req_ready,
  output logic                    rsp_done,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LANES-1:0]        mem_ce_n,
  output logic [LANES-1:0]        mem_we_n,
  output logic                    mem_oe_n,
  output logic [LANES*LANE_W-1:0] mem_dq_out,
  input  logic [LANES*LANE_W-1:0] mem_dq_in,
  output logic                    mem_dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  seq_state_t        state;
  logic              stage_last;
  logic              accept;
  logic              rd_capture;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  lane_mask_q;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign rd_capture = (state == ST_RD_WAIT) && stage_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      wdata_q     <= '0;
      lane_mask_q <= '0;
    end else if (accept) begin
      addr_q      <= req_addr;
      wdata_q     <= req_wdata;
      lane_mask_q <= req_mask;
    end
  end

  sram_seq_fsm #(
    .SETUP_CYC   (SETUP_CYC),
    .WR_PULSE_CYC(WR_PULSE_CYC),
    .WR_RECOV_CYC(WR_RECOV_CYC),
    .RD_WAIT_CYC (RD_WAIT_CYC),
    .TURN_CYC    (TURN_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_write (req_write),
    .state_o     (state),
    .stage_last_o(stage_last)
  );

  sram_lane_drv #(.LANES(LANES)) u_drv (
    .state_i(state),
    .mask_i (lane_mask_q),
    .ce_n_o (mem_ce_n),
    .we_n_o (mem_we_n)
  );

  sram_rd_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture_i(rd_capture),
    .mask_i   (lane_mask_q),
    .dq_i     (mem_dq_in),
    .rdata_o  (rsp_rdata)
  );

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_oe_n   = (state != ST_RD_WAIT);
  assign mem_dq_oe  = drives_bus(state);
  assign rsp_done   = (state == ST_DONE);

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk #(
  parameter int LANES        = 4,
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 32,
  parameter int WR_PULSE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [LANES-1:0]  mem_ce_n,
  input logic [LANES-1:0]  mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic [LANES-1:0]  lane_mask_q
);

  logic       any_we_low;
  logic       any_ce_low;
  logic [7:0] wl_cnt;

  assign any_we_low = ~&mem_we_n;
  assign any_ce_low = ~&mem_ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wl_cnt <= '0;
    else if (any_we_low) wl_cnt <= wl_cnt + 8'd1;
    else                 wl_cnt <= '0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&mem_ce_n && &mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_lane_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mem_ce_n) & (~lane_mask_q)) == '0);

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_we_low && $past(any_we_low)) |-> (int'(wl_cnt) == WR_PULSE_CYC));

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ce_low && $past(any_ce_low)) |-> $stable(mem_addr));

  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  assert_oe_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_we_low || mem_dq_oe) |-> mem_oe_n);

  assert_release_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_oe_n) |-> !mem_dq_oe);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ce_low || rsp_done) |-> !req_ready);

  assert_strobe_in_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mem_we_n) & mem_ce_n) == '0);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .LANES       (LANES),
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .WR_PULSE_CYC(WR_PULSE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .lane_mask_q(lane_mask_q)
);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

  localparam int AW = 19;
  localparam int S  = 1;
  localparam int P  = 3;
  localparam int RC = 1;
  localparam int RD = 3;
  localparam int T  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        req_ready, rsp_done, mem_oe_n, mem_dq_oe;
  logic [31:0] rsp_rdata, mem_dq_out;
  logic [31:0] dq_in_r = '0;
  logic [AW-1:0] mem_addr;
  logic [3:0]  mem_ce_n, mem_we_n;

  int vecs = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sram_lane_ctrl #(
    .ADDR_W(AW), .LANES(4), .LANE_W(8), .SETUP_CYC(S), .WR_PULSE_CYC(P),
    .WR_RECOV_CYC(RC), .RD_WAIT_CYC(RD), .TURN_CYC(T)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(dq_in_r),
    .mem_dq_oe(mem_dq_oe)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(int l, logic [AW-1:0] a);
    return a[7:0] ^ 8'(8'h5A + l * 17);
  endfunction

  function automatic int key_of(int l, logic [AW-1:0] a);
    return (l << AW) | int'(a);
  endfunction

  // ---------------- behavioural memory model, one per lane ----------------
  logic [7:0] mdl_mem [int];
  logic [7:0] exp_mem [int];
  int rd_cnt [4];
  int hold   [4];
  int wl     [4];
  int hi_cnt [4];
  logic [7:0] d_lat [4];
  logic prev_dq_oe = 1'b0;

  function automatic logic [7:0] mdl_byte(int l, logic [AW-1:0] a);
    int k;
    k = key_of(l, a);
    return mdl_mem.exists(k) ? mdl_mem[k] : init_byte(l, a);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 4; l++) begin
        rd_cnt[l] = 0; hold[l] = 0; wl[l] = 0; hi_cnt[l] = 1000; d_lat[l] = '0;
      end
      dq_in_r = '0;
      prev_dq_oe = 1'b0;
    end else begin
      for (int l = 0; l < 4; l++) begin
        logic rd_c;
        int hold_before;
        rd_c = !mem_ce_n[l] && mem_we_n[l] && !mem_oe_n;
        hold_before = hold[l];
        if (mem_ce_n[l] && !mem_we_n[l])
          check(1'b0, "R11 strobe low on a disabled lane", l, -1);
        if (!mem_ce_n[l] && !mem_we_n[l]) begin
          if (wl[l] == 0) begin
            check(hi_cnt[l] >= RC, "R11 strobe high gap", hi_cnt[l], RC);
            check(prev_dq_oe, "R3 data driven before strobe", prev_dq_oe, 1);
          end else begin
            check(mem_dq_out[l*8 +: 8] == d_lat[l], "R4 data stable during strobe",
                  mem_dq_out[l*8 +: 8], d_lat[l]);
          end
          check(mem_dq_oe && mem_oe_n, "R5 bus owned with oe_n high during strobe",
                {mem_dq_oe, mem_oe_n}, 2'b11);
          d_lat[l] = mem_dq_out[l*8 +: 8];
          wl[l]++;
          hi_cnt[l] = 0;
        end else begin
          if (wl[l] > 0) begin
            check(wl[l] == P, "R3 strobe width", wl[l], P);
            check(!mem_ce_n[l], "R3 enable held after strobe", mem_ce_n[l], 0);
            mdl_mem[key_of(l, mem_addr)] = d_lat[l];
            wl[l] = 0;
          end
          if (hi_cnt[l] < 1000) hi_cnt[l]++;
        end
        if (rd_c) rd_cnt[l]++; else rd_cnt[l] = 0;
        if (rd_c) hold[l] = T; else if (hold[l] > 0) hold[l]--;
        if (mem_dq_oe && (rd_c || hold_before > 0))
          check(1'b0, "R8 bus contention", l, -1);
        dq_in_r[l*8 +: 8] = rd_c ? ((rd_cnt[l] >= RD) ? mdl_byte(l, mem_addr) : 8'hEE) : 8'h00;
      end
      prev_dq_oe = mem_dq_oe;
    end
  end

  // ---------------- expected values ----------------
  function automatic logic [31:0] exp_read(logic [AW-1:0] a, logic [3:0] m);
    logic [31:0] r;
    r = '0;
    for (int l = 0; l < 4; l++) begin
      int k;
      k = key_of(l, a);
      if (m[l]) r[l*8 +: 8] = exp_mem.exists(k) ? exp_mem[k] : init_byte(l, a);
    end
    return r;
  endfunction

  logic [31:0] last_rd = '0;

  task automatic op(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                    input logic [3:0] m, input bit inject);
    int lat;
    bit seen_full;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    seen_full = (m == 4'b0);
    while (!rsp_done && lat < 100) begin
      check(!req_ready, "R9 ready low while busy", req_ready, 0);
      check(((~mem_ce_n) & (~m)) == 4'b0, "R2 only masked lanes enabled", ~mem_ce_n, m);
      if (mem_ce_n == ~m) seen_full = 1;
      if (inject && lat == 1) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 19'h1; req_wdata = ~d;
        req_mask = 4'hF;
      end
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    check(!req_ready, "R10 ready low in done cycle", req_ready, 0);
    check(seen_full, "R2 masked lanes enabled together", mem_ce_n, ~m);
    if (wr) begin
      check(lat == S + P + RC, "R3 write latency", lat, S + P + RC);
      check(rsp_rdata == last_rd, "R10 read data kept across write", rsp_rdata, last_rd);
      for (int l = 0; l < 4; l++)
        if (m[l]) exp_mem[key_of(l, a)] = d[l*8 +: 8];
    end else begin
      logic [31:0] e;
      e = exp_read(a, m);
      check(lat == RD + T, "R6 read latency", lat, RD + T);
      check(rsp_rdata == e, "R6 R7 read data", rsp_rdata, e);
      last_rd = rsp_rdata;
    end
    @(negedge clk);
    check(!rsp_done, "R10 done lasts one cycle", rsp_done, 0);
    check(req_ready, "R10 idle after done", req_ready, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_done, "R1 reset handshake", {req_ready, rsp_done}, 2'b10);
    check(mem_ce_n == 4'hF && mem_we_n == 4'hF && mem_oe_n && !mem_dq_oe,
          "R1 reset pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 10'h3FE);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_ce_n == 4'hF && mem_we_n == 4'hF && mem_oe_n && !mem_dq_oe,
          "R1 idle after reset", {req_ready, mem_ce_n, mem_we_n}, 9'h1FF);

    // directed corner cases
    op(0, 19'd5, 32'h0, 4'hF, 0);                  // unwritten word, full read
    op(1, 19'd5, 32'hA1B2C3D4, 4'hF, 0);
    op(0, 19'd5, 32'h0, 4'hF, 0);
    op(1, 19'd5, 32'h11223344, 4'b0001, 0);        // 8-bit
    op(1, 19'd5, 32'h55667788, 4'b0110, 0);        // 16-bit middle
    op(1, 19'd5, 32'h99AABBCC, 4'b1000, 0);
    op(0, 19'd5, 32'h0, 4'hF, 0);
    op(0, 19'd5, 32'h0, 4'b0101, 0);               // R7 zero lanes
    op(1, 19'd5, 32'hDEADBEEF, 4'b0000, 0);        // no lane written
    op(0, 19'd5, 32'h0, 4'hF, 0);
    op(0, 19'd5, 32'h0, 4'b0000, 0);               // R7 all lanes zero
    op(1, 19'h7FFFF, 32'hCAFEF00D, 4'b0111, 0);    // 24-bit at top address
    op(0, 19'h7FFFF, 32'h0, 4'hF, 0);
    op(0, 19'd9, 32'h0, 4'hF, 1);                  // R9 request while busy
    op(0, 19'd8, 32'h0, 4'hF, 0);                  // must show no write at 8

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % 24);
      if ($urandom % 4 == 0) a = a | 19'h7FFE0;
      op(1'($urandom % 2), a, $urandom, 4'($urandom % 16), 1'($urandom % 8 == 0));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule